// File: doc/BRIEF.md
# Edge-Counting Timer Channel with Quadrature Decode

This block is one 16-bit event-counting timer channel. It counts either edges on an external count pin or cycles in which an internal trigger strobe is high. The direction of each step comes from a software direction input or from the level of a second pin. When the counter passes its end of range it either reloads from a reload register or wraps freely. In both cases it raises a one-clock event pulse.

On channels built with the two-phase option, the count pin and the direction pin can instead be read as the two phases of a quadrature encoder. In that mode the block counts either once per full encoder cycle or on every phase edge (times-four decoding). Software sets the behaviour through an 8-bit mode register. Both external pins pass through a synchronizer before any edge is detected.

Top module: `evtcnt_chan`

## Requirements
- R1: The mode register resets to 00h and reads back what was written, except that bit 2 always reads 0. Bit fields: [1:0] operating mode, [3] rising-edge select, [4] direction from pin, [5] spare, [6] free-running, [7] times-four.
- R2: The counter steps only while `start` is 1 and mode bits [1:0] equal 01. Otherwise it holds its value.
- R3: A write to the reload register always updates the reload value. The write also loads the counter, but only while `start` is 0. While `start` is 1, the write leaves the counter unchanged.
- R4: With `src_sel`=0 and single-phase operation, bit 3 = 0 counts falling edges of `cnt_pin` and bit 3 = 1 counts rising edges. Each counted edge is visible on `count_q` within four clock cycles.
- R5: With `src_sel`=1, each clock cycle in which `trig_in` is high counts one step. Bit 3 and `cnt_pin` have no effect in this case.
- R6: With bit 4 = 0, the direction is `sw_up` (1 counts up). With bit 4 = 1, a high `dir_pin` counts up and a low `dir_pin` counts down.
- R7: With bit 6 = 0, counting down from 0000h or up from FFFFh loads the reload value and pulses `wrap_evt` for one clock.
- R8: With bit 6 = 1, the counter wraps modulo 2^16 and pulses `wrap_evt` on each wrap.
- R9: With `quad_en`=1 and bit 7 = 0, the channel counts once per rising edge of `cnt_pin` (phase A). The step is up if `dir_pin` (phase B) is low and down if it is high. No other phase edge counts.
- R10: With `quad_en`=1 and bit 7 = 1, every single-phase transition counts. The {A,B} sequence 00,10,11,01 counts up and the reverse sequence counts down. A transition in which both phases change at once is ignored.
- R11: On a channel built without the two-phase option, mode bit 7 always reads 0 and `quad_en` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | 8 | Mode register write data |
| mode_rdata | output | 8 | Mode register read-back |
| reload_we | input | 1 | Reload register write strobe |
| reload_wdata | input | 16 | Reload register write data |
| start | input | 1 | Counting enable |
| sw_up | input | 1 | Software count direction, 1 = up |
| src_sel | input | 1 | Count source: 0 = pin, 1 = internal trigger |
| trig_in | input | 1 | Internal trigger strobe |
| quad_en | input | 1 | Two-phase decode enable |
| cnt_pin | input | 1 | Count pin / phase A |
| dir_pin | input | 1 | Direction pin / phase B |
| count_q | output | 16 | Counter value |
| wrap_evt | output | 1 | One-clock underflow/overflow event |

## Verification
A corrupted synchronizer or previous-level register shows up as one missing or extra count on `count_q`, at most four clocks after the pin edge. A wrongly stored mode bit shows up at once on `mode_rdata`. Its effect on counting appears as a wrong direction or a wrong edge choice at the first counted edge. A bad wrap path shows up on the clock after the end-of-range step, as a wrong reload value or a missing `wrap_evt` pulse. The quadrature paths are driven through full forward and reverse encoder cycles and an illegal double transition, so that a swapped phase or a swapped direction changes the final count.

// File: rtl/evtcnt_pkg.sv
package evtcnt_pkg;
  localparam int MODE_W = 8;
  localparam logic [1:0] OPM_EVENT = 2'b01;

  typedef struct packed {
    logic       x4;        // [7] times-four two-phase decode
    logic       free_run;  // [6] 1 = wrap freely, 0 = reload
    logic       spare;     // [5] stored only
    logic       dir_pin;   // [4] direction from pin level
    logic       rising;    // [3] 1 = rising edges, 0 = falling
    logic       rsvd;      // [2] always 0
    logic [1:0] opm;       // [1:0] operating mode
  } mode_t;
endpackage

// File: rtl/evtcnt_sync.sv
module evtcnt_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg <= '0;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/evtcnt_decode.sv
module evtcnt_decode #(
  parameter bit HAS_QUAD = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic pha,
  input  logic phb,
  input  logic src_sel,
  input  logic trig_in,
  input  logic rising,
  input  logic dir_from_pin,
  input  logic sw_up,
  input  logic quad_en,
  input  logic x4,
  output logic step,
  output logic up
);
  logic prev_a, prev_b;
  logic a_rise, a_fall;
  logic single_ev, single_up;
  logic quad_on, q_ev, q_up;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_a <= 1'b0;
      prev_b <= 1'b0;
    end else begin
      prev_a <= pha;
      prev_b <= phb;
    end
  end

  assign a_rise = ~prev_a & pha;
  assign a_fall = prev_a & ~pha;

  always_comb begin
    if (src_sel) single_ev = trig_in;
    else         single_ev = rising ? a_rise : a_fall;
    single_up = dir_from_pin ? phb : sw_up;
  end

  generate
    if (HAS_QUAD) begin : g_quad
      logic da, db;
      assign da      = pha ^ prev_a;
      assign db      = phb ^ prev_b;
      assign quad_on = quad_en;
      always_comb begin
        if (x4) begin
          q_ev = da ^ db;
          q_up = pha ^ prev_b;
        end else begin
          q_ev = a_rise;
          q_up = ~phb;
        end
      end

      // R10: an illegal double transition never produces a step
      a_r10_no_double: assert property (@(posedge clk) disable iff (rst)
        (quad_en && x4 && (pha != prev_a) && (phb != prev_b)) |-> !step);
    end else begin : g_noquad
      logic unused_quad;
      assign unused_quad = quad_en ^ x4;
      assign quad_on = 1'b0;
      assign q_ev    = 1'b0;
      assign q_up    = 1'b0;
    end
  endgenerate

  assign step = quad_on ? q_ev : single_ev;
  assign up   = quad_on ? q_up : single_up;
endmodule

// File: rtl/evtcnt_core.sv
module evtcnt_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reload_we,
  input  logic [CNT_W-1:0] reload_wdata,
  input  logic             preset_we,
  input  logic             step,
  input  logic             up,
  input  logic             free_run,
  output logic [CNT_W-1:0] count_q,
  output logic             wrap_evt
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] reload_q;
  logic at_top, at_bot, wrap_now;

  assign at_top   = (count_q == '1);
  assign at_bot   = (count_q == '0);
  assign wrap_now = step && (up ? at_top : at_bot);

  always_ff @(posedge clk) begin
    if (rst) reload_q <= '0;
    else if (reload_we) reload_q <= reload_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q  <= '0;
      wrap_evt <= 1'b0;
    end else begin
      wrap_evt <= 1'b0;
      if (preset_we) begin
        count_q <= reload_wdata;
      end else if (step) begin
        if (wrap_now) begin
          wrap_evt <= 1'b1;
          if (free_run) count_q <= up ? '0 : '1;
          else          count_q <= reload_q;
        end else begin
          count_q <= up ? count_q + ONE : count_q - ONE;
        end
      end
    end
  end

  // R2: with no step and no preset the counter holds
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    (!step && !preset_we) |=> $stable(count_q));
  // R7: reload-mode end-of-range loads the reload value and pulses the event
  a_r7_reload_wrap: assert property (@(posedge clk) disable iff (rst)
    (step && !preset_we && !free_run && ((up && count_q == '1) || (!up && count_q == '0)))
    |=> (count_q == $past(reload_q)) && wrap_evt);
  // R8: free-running upward wrap goes to zero and pulses the event
  a_r8_free_wrap: assert property (@(posedge clk) disable iff (rst)
    (step && !preset_we && free_run && up && count_q == '1) |=> (count_q == '0) && wrap_evt);
  // R7: an event pulse is always caused by a step
  a_r7_evt_cause: assert property (@(posedge clk) disable iff (rst)
    wrap_evt |-> $past(step));
endmodule

// File: rtl/evtcnt_chan.sv
module evtcnt_chan
  import evtcnt_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter bit HAS_QUAD    = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_we,
  input  logic [7:0]       mode_wdata,
  output logic [7:0]       mode_rdata,
  input  logic             reload_we,
  input  logic [CNT_W-1:0] reload_wdata,
  input  logic             start,
  input  logic             sw_up,
  input  logic             src_sel,
  input  logic             trig_in,
  input  logic             quad_en,
  input  logic             cnt_pin,
  input  logic             dir_pin,
  output logic [CNT_W-1:0] count_q,
  output logic             wrap_evt
);
  localparam logic [MODE_W-1:0] WMASK = HAS_QUAD ? 8'hFB : 8'h7B;

  mode_t      mode_r;
  logic [1:0] pins_s;
  logic       raw_step, raw_up, run, step_g;

  always_ff @(posedge clk) begin
    if (rst) mode_r <= '0;
    else if (mode_we) mode_r <= mode_t'(mode_wdata & WMASK);
  end
  assign mode_rdata = mode_r;

  evtcnt_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({dir_pin, cnt_pin}),
    .q   (pins_s)
  );

  evtcnt_decode #(.HAS_QUAD(HAS_QUAD)) u_dec (
    .clk          (clk),
    .rst          (rst),
    .pha          (pins_s[0]),
    .phb          (pins_s[1]),
    .src_sel      (src_sel),
    .trig_in      (trig_in),
    .rising       (mode_r.rising),
    .dir_from_pin (mode_r.dir_pin),
    .sw_up        (sw_up),
    .quad_en      (quad_en),
    .x4           (mode_r.x4),
    .step         (raw_step),
    .up           (raw_up)
  );

  assign run    = start && (mode_r.opm == OPM_EVENT);
  assign step_g = run && raw_step;

  evtcnt_core #(.CNT_W(CNT_W)) u_core (
    .clk          (clk),
    .rst          (rst),
    .reload_we    (reload_we),
    .reload_wdata (reload_wdata),
    .preset_we    (reload_we && !start),
    .step         (step_g),
    .up           (raw_up),
    .free_run     (mode_r.free_run),
    .count_q      (count_q),
    .wrap_evt     (wrap_evt)
  );

  // R2: while not running and not preset the counter value is frozen
  a_r2_idle: assert property (@(posedge clk) disable iff (rst)
    (!(start && mode_rdata[1:0] == 2'b01) && !reload_we) |=> $stable(count_q));
  // R3: a reload write while started leaves the counter to the count path
  a_r3_no_preset_running: assert property (@(posedge clk) disable iff (rst)
    (start && reload_we && !step_g) |=> $stable(count_q));
  // R8: wrap event never fires while stopped
  a_r8_evt_needs_run: assert property (@(posedge clk) disable iff (rst)
    wrap_evt |-> $past(start));
endmodule

// File: tb/evtcnt_chan_bench.sv
`timescale 1ns/1ps
module evtcnt_chan_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_we = 0, reload_we = 0, start = 0, sw_up = 0, src_sel = 0;
  logic trig_in = 0, quad_en = 0, cnt_pin = 0, dir_pin = 0;
  logic [7:0] mode_wdata = 0;
  logic [15:0] reload_wdata = 0;
  logic [7:0] mode_rdata, p_mode_rdata;
  logic [15:0] count_q, p_count_q;
  logic wrap_evt, p_wrap_evt;
  int n_chk = 0, n_bad = 0, evt_seen = 0;
  bit done = 0;

  always #10 clk = ~clk;

  evtcnt_chan u_evtcnt_chan (
    .clk(clk), .rst(rst), .mode_we(mode_we), .mode_wdata(mode_wdata), .mode_rdata(mode_rdata),
    .reload_we(reload_we), .reload_wdata(reload_wdata), .start(start), .sw_up(sw_up),
    .src_sel(src_sel), .trig_in(trig_in), .quad_en(quad_en), .cnt_pin(cnt_pin),
    .dir_pin(dir_pin), .count_q(count_q), .wrap_evt(wrap_evt));

  evtcnt_chan #(.HAS_QUAD(1'b0)) u_evtcnt_chan_plain (
    .clk(clk), .rst(rst), .mode_we(mode_we), .mode_wdata(mode_wdata), .mode_rdata(p_mode_rdata),
    .reload_we(reload_we), .reload_wdata(reload_wdata), .start(start), .sw_up(sw_up),
    .src_sel(src_sel), .trig_in(trig_in), .quad_en(quad_en), .cnt_pin(cnt_pin),
    .dir_pin(dir_pin), .count_q(p_count_q), .wrap_evt(p_wrap_evt));

  always @(posedge clk) if (wrap_evt) evt_seen <= evt_seen + 1;

  // {mode[8], preset[16], sw_up, dir_pin, pulses[8], expected[16]}
  localparam logic [49:0] VECS [12] = '{
    {8'h01, 16'd100,   1'b0, 1'b0, 8'd5, 16'd95},    // R4 falling, R6 sw down
    {8'h01, 16'd100,   1'b1, 1'b0, 8'd5, 16'd105},   // R6 sw up
    {8'h09, 16'd10,    1'b0, 1'b0, 8'd3, 16'd7},     // R4 rising
    {8'h11, 16'd0,     1'b0, 1'b1, 8'd4, 16'd4},     // R6 pin high up
    {8'h11, 16'd50,    1'b0, 1'b0, 8'd7, 16'd43},    // R6 pin low down
    {8'h19, 16'd2,     1'b0, 1'b0, 8'd2, 16'd0},     // R4 R6
    {8'h41, 16'd1,     1'b0, 1'b0, 8'd3, 16'hFFFE},  // R8 down wrap
    {8'h01, 16'd1,     1'b0, 1'b0, 8'd3, 16'd0},     // R7 underflow reload
    {8'h41, 16'hFFFE,  1'b1, 1'b0, 8'd3, 16'd1},     // R8 up wrap
    {8'h00, 16'd7,     1'b1, 1'b0, 8'd3, 16'd7},     // R2 wrong mode field
    {8'h01, 16'hFFFF,  1'b1, 1'b0, 8'd2, 16'hFFFF},  // R7 overflow reload
    {8'h59, 16'd5,     1'b0, 1'b1, 8'd2, 16'd7}      // R4 R6 R8 combined
  };

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_mode(input logic [7:0] v);
    mode_we = 1; mode_wdata = v; tick(1); mode_we = 0;
  endtask

  task automatic wr_reload(input logic [15:0] v);
    reload_we = 1; reload_wdata = v; tick(1); reload_we = 0;
  endtask

  task automatic pulse();
    cnt_pin = ~cnt_pin; tick(4); cnt_pin = ~cnt_pin; tick(4);
  endtask

  task automatic qstep(input logic a, input logic b);
    cnt_pin = a; dir_pin = b; tick(4);
  endtask

  task automatic qfwd();
    qstep(1, 0); qstep(1, 1); qstep(0, 1); qstep(0, 0);
  endtask

  task automatic qrev();
    qstep(0, 1); qstep(1, 1); qstep(1, 0); qstep(0, 0);
  endtask

  initial begin
    int e0;
    tick(3);
    rst = 0;
    tick(1);
    // reset state
    check("R1 reset mode", mode_rdata, 8'h00);
    check("R1 reset count", count_q, 16'h0);
    check("R7 reset evt", wrap_evt, 1'b0);

    // R1 reserved bit, R11 plain channel masks bit 7
    wr_mode(8'hFF);
    check("R1 readback", mode_rdata, 8'hFB);
    check("R11 plain readback", p_mode_rdata, 8'h7B);

    // vector table
    for (int i = 0; i < 12; i++) begin
      logic [49:0] v;
      v = VECS[i];
      start = 0; src_sel = 0; quad_en = 0;
      wr_mode(v[49:42]);
      wr_reload(v[41:26]);
      sw_up = v[25]; dir_pin = v[24];
      tick(4);
      start = 1;
      for (int p = 0; p < int'(v[23:16]); p++) pulse();
      start = 0;
      tick(1);
      check("R2 R4 R6 R7 R8 vector", count_q, v[15:0]);
    end

    // R2: stopped channel ignores pin edges
    dir_pin = 0; wr_mode(8'h01); wr_reload(16'd20); sw_up = 1; tick(4);
    pulse(); pulse();
    check("R2 stopped hold", count_q, 16'd20);

    // R5: trigger source, pin and polarity ignored
    wr_mode(8'h09); src_sel = 1; wr_reload(16'd0); start = 1;
    for (int k = 0; k < 3; k++) begin
      trig_in = 1; tick(1); trig_in = 0; tick(2);
    end
    pulse();
    check("R5 trigger count", count_q, 16'd3);
    start = 0; src_sel = 0;

    // R3 + R7: reload write while running, then underflow pulses event
    wr_mode(8'h01); sw_up = 0; wr_reload(16'd0); start = 1;
    wr_reload(16'h1234);
    check("R3 no preset while running", count_q, 16'd0);
    e0 = evt_seen;
    pulse();
    check("R7 reload value", count_q, 16'h1234);
    check("R7 one event", evt_seen - e0, 1);
    start = 0;

    // R8: free-running overflow event
    wr_mode(8'h41); sw_up = 1; wr_reload(16'hFFFF); start = 1;
    e0 = evt_seen;
    pulse();
    check("R8 wrap to zero", count_q, 16'd0);
    check("R8 one event", evt_seen - e0, 1);
    start = 0;

    // R9: normal two-phase
    cnt_pin = 0; dir_pin = 0; quad_en = 1;
    wr_mode(8'h11); wr_reload(16'd10); tick(4); start = 1;
    qfwd(); qfwd();
    check("R9 forward", count_q, 16'd12);
    qrev(); qrev(); qrev();
    check("R9 reverse", count_q, 16'd9);
    start = 0;

    // R10: times-four, R11 plain channel ignores quad_en
    wr_mode(8'h91);
    check("R11 plain x4 bit", p_mode_rdata, 8'h11);
    wr_reload(16'd10); tick(4); start = 1;
    qfwd(); qfwd();
    check("R10 x4 forward", count_q, 16'd18);
    check("R11 plain forward", p_count_q, 16'd12);
    qrev();
    check("R10 x4 reverse", count_q, 16'd14);
    qstep(1, 1);
    check("R10 double ignored", count_q, 16'd14);
    qstep(0, 0);
    check("R10 double back ignored", count_q, 16'd14);
    check("R11 plain single-phase", p_count_q, 16'd10);
    start = 0;

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    done = 1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule